// File: doc/BRIEF.md
# Receiver Acquisition Mode Sequencer

This block steers the receive side of a narrowband data modem through its start-up and fade handling. It watches three control lines: a request to acquire bit timing, a request to acquire signal levels, and an active-low freeze. It also watches a strobe that pulses once per received bit. From these it drives two 2-bit mode codes. One selects how hard the clock-recovery loop may correct its phase. The other selects how the level detectors that set the slicing thresholds behave.

All control lines are sampled on the bit strobe, so every mode change lands on a bit boundary. When clock acquisition ends, the loop spends a fixed number of bit periods at medium bandwidth, then settles to narrow bandwidth. A freeze stops that count, and the count picks up again when the freeze ends. A new level-acquire request gives one clamp bit, then fast peak tracking for as long as the request stays high. Either acquire request overrides the freeze on its own path.

Top module: `rx_acq_seq`

## Requirements
- R1: While the sampled clock-acquire line is high, the loop code is 0 (acquire), whatever the freeze line does.
- R2: After clock-acquire is sampled falling with the freeze released, the loop code is 1 (medium) for exactly MED_BITS bit periods.
- R3: Once the medium window has run out and clock-acquire is low with the freeze released, the loop code is 2 (narrow). The same holds after reset when no acquire has been requested.
- R4: With clock-acquire low and the freeze line low, the loop code is 3 (hold). A freeze inside the medium window pauses the window, so the total number of medium periods stays MED_BITS.
- R5: A sampled rising edge on level-acquire gives level code 0 (clamp) for exactly one bit period.
- R6: After the clamp bit, the level code is 1 (fast peak) for as long as level-acquire stays high, with or without the freeze.
- R7: With level-acquire low, the level code is 2 (averaging peak) when the freeze is released and 3 (hold) when it is applied.
- R8: Inputs are taken only on cycles where bit_tick is high. The outputs change only on the clock edge that follows such a cycle, and a pulse on an input between ticks has no effect.
- R9: During and right after reset, both codes are 3 (hold), and the medium window is empty.
- R10: A new clock-acquire falling edge reloads a full MED_BITS window, even if an earlier window was not finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per received bit |
| clk_acq | input | 1 | Clock-loop acquire request, active high |
| lvl_acq | input | 1 | Level-measurement acquire request, active high |
| hold_n | input | 1 | Freeze request, active low |
| loop_mode | output | 2 | 0 acquire, 1 medium, 2 narrow, 3 hold |
| lvl_mode | output | 2 | 0 clamp, 1 fast peak, 2 averaging peak, 3 hold |

## Verification
The bench builds the block with the default window of 30 bits and a bit strobe every fourth clock. Because of that spacing, pulses placed between strobes can show that nothing is sampled mid-bit. The full 30-bit window is short enough to run several times: once uninterrupted, once with a freeze in the middle, and once cut short and restarted. The total number of medium-bandwidth clocks then shows both the pause rule and the reload rule.

// File: rtl/rx_acq_seq.sv
module rx_acq_seq #(
  parameter int MED_BITS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       clk_acq,
  input  logic       lvl_acq,
  input  logic       hold_n,
  output logic [1:0] loop_mode,
  output logic [1:0] lvl_mode
);
  localparam int CW = $clog2(MED_BITS + 1);
  localparam logic [CW-1:0] LOAD = CW'(MED_BITS);

  localparam logic [1:0] L_ACQ = 2'd0, L_MED = 2'd1, L_NAR = 2'd2, L_HOLD = 2'd3;
  localparam logic [1:0] V_CLAMP = 2'd0, V_FAST = 2'd1, V_AVG = 2'd2, V_HOLD = 2'd3;

  logic          ca_q, la_q, frz_q, clamp_q;
  logic [CW-1:0] med_left;
  logic          ca_fall;

  assign ca_fall = ca_q & ~clk_acq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_q     <= 1'b0;
      la_q     <= 1'b0;
      frz_q    <= 1'b1;
      clamp_q  <= 1'b0;
      med_left <= '0;
    end else if (bit_tick) begin
      ca_q    <= clk_acq;
      la_q    <= lvl_acq;
      frz_q   <= ~hold_n;
      clamp_q <= lvl_acq & ~la_q;
      if (clk_acq)
        med_left <= '0;
      else if (ca_fall)
        med_left <= LOAD;
      else if (!frz_q && med_left != '0)
        med_left <= med_left - 1'b1;
    end
  end

  assign loop_mode = ca_q             ? L_ACQ  :
                     frz_q            ? L_HOLD :
                     (med_left != '0) ? L_MED  : L_NAR;

  assign lvl_mode  = clamp_q ? V_CLAMP :
                     la_q    ? V_FAST  :
                     frz_q   ? V_HOLD  : V_AVG;
endmodule

// File: rtl/rx_acq_seq_chk.sv
module rx_acq_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       clk_acq,
  input logic       lvl_acq,
  input logic       hold_n,
  input logic [1:0] loop_mode,
  input logic [1:0] lvl_mode
);
  AST_ACQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && clk_acq |=> loop_mode == 2'd0); // R1
  AST_LOOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && !clk_acq && !hold_n |=> loop_mode == 2'd3); // R4
  AST_CLAMP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && lvl_mode == 2'd0 |=> lvl_mode != 2'd0); // R5
  AST_LVL_ACQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && lvl_acq |=> lvl_mode == 2'd0 || lvl_mode == 2'd1); // R6
  AST_LVL_AVERAGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && !lvl_acq && hold_n |=> lvl_mode == 2'd2); // R7
  AST_LVL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && !lvl_acq && !hold_n |=> lvl_mode == 2'd3); // R7
  AST_NO_MIDBIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(loop_mode) && $stable(lvl_mode)); // R8
endmodule

bind rx_acq_seq rx_acq_seq_chk u_chk (.*);

// File: tb/rx_acq_seq_test.sv
module rx_acq_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_EVERY = 4;
  localparam int WIN = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic clk_acq = 1'b0;
  logic lvl_acq = 1'b0;
  logic hold_n = 1'b1;
  logic [1:0] loop_mode, lvl_mode;

  int checks = 0;
  int fails = 0;
  int med_cycles = 0;
  int clamp_cycles = 0;
  bit done = 1'b0;

  // reference model state
  bit m_ca = 0, m_la = 0, m_frz = 1, m_clamp = 0;
  int m_left = 0;
  logic [1:0] e_loop, e_lvl;

  rx_acq_seq #(.MED_BITS(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .clk_acq(clk_acq),
    .lvl_acq(lvl_acq), .hold_n(hold_n), .loop_mode(loop_mode), .lvl_mode(lvl_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % TICK_EVERY;
      bit_tick = (phase == 0);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ca = 0; m_la = 0; m_frz = 1; m_clamp = 0; m_left = 0;
    end else if (bit_tick) begin
      if (clk_acq) m_left = 0;
      else if (m_ca) m_left = WIN;
      else if (!m_frz && m_left > 0) m_left = m_left - 1;
      m_clamp = lvl_acq && !m_la;
      m_ca = clk_acq; m_la = lvl_acq; m_frz = !hold_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    e_loop = m_ca ? 2'd0 : m_frz ? 2'd3 : (m_left > 0) ? 2'd1 : 2'd2;
    e_lvl  = m_clamp ? 2'd0 : m_la ? 2'd1 : m_frz ? 2'd3 : 2'd2;
    if (!done) begin
      case (e_loop)
        2'd0: check(loop_mode == e_loop, "R1 loop", loop_mode, e_loop);
        2'd1: check(loop_mode == e_loop, "R2 loop", loop_mode, e_loop);
        2'd2: check(loop_mode == e_loop, "R3 loop", loop_mode, e_loop);
        default: check(loop_mode == e_loop, "R4 loop", loop_mode, e_loop);
      endcase
      case (e_lvl)
        2'd0: check(lvl_mode == e_lvl, "R5 level", lvl_mode, e_lvl);
        2'd1: check(lvl_mode == e_lvl, "R6 level", lvl_mode, e_lvl);
        default: check(lvl_mode == e_lvl, "R7 level", lvl_mode, e_lvl);
      endcase
    end
    if (loop_mode == 2'd1) med_cycles++;
    if (lvl_mode == 2'd0) clamp_cycles++;
  end

  task automatic bits(input int n);
    repeat (n) @(posedge clk iff bit_tick);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int snap, csnap;
    logic [1:0] keep;
    repeat (5) @(negedge clk);
    check(loop_mode == 2'd3, "R9 reset loop", loop_mode, 3);
    check(lvl_mode == 2'd3, "R9 reset level", lvl_mode, 3);
    rst_n = 1'b1;
    bits(1);
    check(loop_mode == 2'd2, "R3 narrow after reset", loop_mode, 2);
    check(lvl_mode == 2'd2, "R7 average after reset", lvl_mode, 2);

    // R2 / R5 / R6: plain acquisition
    csnap = clamp_cycles;
    clk_acq = 1; lvl_acq = 1;
    bits(20);
    check(clamp_cycles - csnap == TICK_EVERY, "R5 clamp length", clamp_cycles - csnap, TICK_EVERY);
    check(lvl_mode == 2'd1, "R6 fast peak", lvl_mode, 1);
    snap = med_cycles;
    clk_acq = 0; lvl_acq = 0;
    bits(45);
    check(med_cycles - snap == WIN * TICK_EVERY, "R2 medium length", med_cycles - snap, WIN * TICK_EVERY);
    check(loop_mode == 2'd2, "R3 narrow after window", loop_mode, 2);

    // R4: freeze in the middle of the window, R6 acquire beats freeze
    clk_acq = 1; bits(5);
    snap = med_cycles;
    clk_acq = 0; bits(10);
    hold_n = 0; bits(3);
    check(loop_mode == 2'd3, "R4 loop frozen", loop_mode, 3);
    check(lvl_mode == 2'd3, "R7 level frozen", lvl_mode, 3);
    csnap = clamp_cycles;
    lvl_acq = 1; bits(4);
    check(lvl_mode == 2'd1, "R6 fast under freeze", lvl_mode, 1);
    check(clamp_cycles - csnap == TICK_EVERY, "R5 clamp under freeze", clamp_cycles - csnap, TICK_EVERY);
    lvl_acq = 0; bits(8);
    hold_n = 1; bits(40);
    check(med_cycles - snap == WIN * TICK_EVERY, "R4 paused window total", med_cycles - snap, WIN * TICK_EVERY);

    // R10: restart
    clk_acq = 1; bits(3);
    snap = med_cycles;
    clk_acq = 0; bits(10);
    clk_acq = 1; bits(2);
    clk_acq = 0; bits(45);
    check(med_cycles - snap == (10 + WIN) * TICK_EVERY, "R10 window reload", med_cycles - snap, (10 + WIN) * TICK_EVERY);

    // R1: acquire beats freeze
    hold_n = 0; clk_acq = 1; bits(3);
    check(loop_mode == 2'd0, "R1 acquire under freeze", loop_mode, 0);
    clk_acq = 0; hold_n = 1; bits(2);

    // R8: mid-bit pulses ignored
    @(posedge clk iff bit_tick);
    @(negedge clk);
    keep = loop_mode;
    clk_acq = 1; lvl_acq = 1; hold_n = 0;
    @(negedge clk);
    clk_acq = 0; lvl_acq = 0; hold_n = 1;
    bits(1);
    check(loop_mode == keep, "R8 mid-bit loop", loop_mode, keep);
    check(lvl_mode == 2'd2, "R8 mid-bit level", lvl_mode, 2);

    bits(2);
    finish_run();
  end
endmodule